// File: doc/BRIEF.md
# Dual FIFO Trigger Control Unit

This block holds the character buffering for one serial channel: a transmit FIFO and a receive FIFO, each 64 characters of 8 bits by default. The serializer and deserializer that sit outside the block move characters through four valid/ready streams. The transmit side is filled by the host and drained by the transmit shifter. The receive side is filled by the receive shifter and drained by the host. A transfer happens on a rising clock edge where valid and ready are both high. A producer that sees ready low must hold its character and retry. A consumer may only take data while valid is high.

A write-only control strobe loads an 8-bit control word. The word does five things: it switches both FIFOs between full depth and a single-character holding mode, flushes either FIFO, sets the receive threshold, sets the transmit threshold and sets a DMA signalling mode bit. The transmit threshold field is protected: it only loads while the enhanced-function input is high. The unit raises a receive trigger flag when enough characters are waiting. It raises a transmit trigger flag when enough free room exists.

Top module: `dual_fifo_trig`

## Requirements
- R1: After reset the control state is all zero. Both FIFOs are disabled and empty, both trigger flags are low, `dma_mode` is 0, and both in-side streams show ready.
- R2: With the FIFOs enabled (control bit 0 = 1), each FIFO accepts up to 64 characters and returns them in arrival order. In-side ready is low while the level equals 64.
- R3: With control bit 0 = 0, each FIFO holds at most one character. In-side ready is low while one character is stored.
- R4: Control bits 7:6 set the receive threshold: 00 = 8, 01 = 16, 10 = 56, 11 = 60 characters. `rx_trig` is high while the FIFOs are enabled and `rx_level` is at least the threshold.
- R5: Control bits 5:4 set the transmit threshold in free places: 00 = 8, 01 = 16, 10 = 32, 11 = 56. `tx_trig` is high while the FIFOs are enabled and (64 − `tx_level`) is at least the threshold.
- R6: A control write changes the transmit threshold only while `enh_en` is 1. Otherwise the previous threshold is kept, and the other fields still load.
- R7: Control bit 3 drives `dma_mode` (0 = mode 0, 1 = mode 1).
- R8: A control write with bit 2 = 1 empties the transmit FIFO: `tx_level` reads 0 on the next cycle. The receive FIFO is unchanged.
- R9: A control write with bit 1 = 1 empties the receive FIFO: `rx_level` reads 0 on the next cycle. The transmit FIFO is unchanged.
- R10: A flush and an accepted push to the same FIFO in the same cycle leave that FIFO empty.
- R11: A push offered while in-side ready is low, or a pop requested while out-side valid is low, stores nothing and removes nothing. It raises the matching `tx_err`/`rx_err` for exactly one cycle after the attempt.
- R12: Control fields take effect on the cycle after the write. A flush acts only on the write that carries it: a later write with bits 2:1 = 00 leaves stored characters in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_data | input | 8 | Control word |
| enh_en | input | 1 | Enhanced-function enable; gates the transmit threshold field |
| tx_in_valid | input | 1 | Host offers a transmit character |
| tx_in_ready | output | 1 | Transmit FIFO can accept |
| tx_in_data | input | 8 | Transmit character in |
| tx_out_valid | output | 1 | Transmit character available to the shifter |
| tx_out_ready | input | 1 | Shifter takes the transmit character |
| tx_out_data | output | 8 | Transmit character out |
| rx_in_valid | input | 1 | Receive shifter offers a character |
| rx_in_ready | output | 1 | Receive FIFO can accept |
| rx_in_data | input | 8 | Receive character in |
| rx_out_valid | output | 1 | Received character available to the host |
| rx_out_ready | input | 1 | Host takes the received character |
| rx_out_data | output | 8 | Received character out |
| tx_level | output | 7 | Characters stored in the transmit FIFO |
| rx_level | output | 7 | Characters stored in the receive FIFO |
| rx_trig | output | 1 | Receive threshold reached |
| tx_trig | output | 1 | Transmit free-space threshold reached |
| dma_mode | output | 1 | Selected DMA signalling mode |
| tx_err | output | 1 | One-cycle pulse on transmit overflow or underflow attempt |
| rx_err | output | 1 | One-cycle pulse on receive overflow or underflow attempt |

## Verification
The bench walks the receive level through each threshold boundary, one character below it and then at it. A design with a swapped or off-by-one table would raise `rx_trig` at the wrong count. It parks the transmit level where the free space sits between thresholds. It then writes the transmit field with `enh_en` low and high: a design that ignores the guard would flip `tx_trig` when it should hold. Flush, single-character mode, overflow and underflow are hit directly, along with a flush that lands on the same edge as a push. A design that let the push win would leave one character behind, and one without error pulses or with a sticky flush would change the levels or the flags.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef struct packed {
    logic [1:0] rx_sel;
    logic [1:0] tx_sel;
    logic       dma;
    logic       en;
  } fifo_cfg_t;

  // receive threshold in stored characters
  function automatic logic [31:0] rx_thr(input logic [1:0] sel);
    case (sel)
      2'b00:   return 32'd8;
      2'b01:   return 32'd16;
      2'b10:   return 32'd56;
      default: return 32'd60;
    endcase
  endfunction

  // transmit threshold in free places
  function automatic logic [31:0] tx_thr(input logic [1:0] sel);
    case (sel)
      2'b00:   return 32'd8;
      2'b01:   return 32'd16;
      2'b10:   return 32'd32;
      default: return 32'd56;
    endcase
  endfunction

endpackage

// File: rtl/uart_char_fifo.sv
module uart_char_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] level,
  output logic          err
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cap;
  logic          push, pop;

  assign cap       = fifo_en ? CW'(DEPTH) : CW'(1);
  assign in_ready  = cnt < cap;
  assign out_valid = cnt != '0;
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rp];
  assign level     = cnt;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      err <= 1'b0;
    end else begin
      err <= (in_valid && !in_ready) || (out_ready && !out_valid);
      if (flush) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push) wp <= step(wp);
        if (pop)  rp <= step(rp);
        case ({push, pop})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_data,
  input  logic       enh_en,
  output fifo_cfg_t  cfg,
  output logic       tx_flush,
  output logic       rx_flush
);

  // flush bits act on the write cycle only and are never stored
  assign tx_flush = ctl_wr && ctl_data[2];
  assign rx_flush = ctl_wr && ctl_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (ctl_wr) begin
      cfg.rx_sel <= ctl_data[7:6];
      cfg.dma    <= ctl_data[3];
      cfg.en     <= ctl_data[0];
      if (enh_en) cfg.tx_sel <= ctl_data[5:4];
    end
  end

endmodule

// File: rtl/uart_trig_eval.sv
module uart_trig_eval
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  fifo_cfg_t     cfg,
  input  logic [CW-1:0] rx_level,
  input  logic [CW-1:0] tx_level,
  output logic          rx_trig,
  output logic          tx_trig
);

  logic [31:0] tx_free;

  assign tx_free = 32'(DEPTH) - 32'(tx_level);
  assign rx_trig = cfg.en && (32'(rx_level) >= rx_thr(cfg.rx_sel));
  assign tx_trig = cfg.en && (tx_free >= tx_thr(cfg.tx_sel));

endmodule

// File: rtl/dual_fifo_trig.sv
module dual_fifo_trig
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_data,
  input  logic          enh_en,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [W-1:0]  tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [W-1:0]  tx_out_data,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [W-1:0]  rx_in_data,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [W-1:0]  rx_out_data,
  output logic [CW-1:0] tx_level,
  output logic [CW-1:0] rx_level,
  output logic          rx_trig,
  output logic          tx_trig,
  output logic          dma_mode,
  output logic          tx_err,
  output logic          rx_err
);

  fifo_cfg_t cfg;
  logic      tx_flush, rx_flush;

  uart_fifo_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .enh_en(enh_en), .cfg(cfg), .tx_flush(tx_flush), .rx_flush(rx_flush)
  );

  uart_char_fifo #(.DEPTH(DEPTH), .W(W)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .fifo_en(cfg.en), .flush(tx_flush),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .level(tx_level), .err(tx_err)
  );

  uart_char_fifo #(.DEPTH(DEPTH), .W(W)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .fifo_en(cfg.en), .flush(rx_flush),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .level(rx_level), .err(rx_err)
  );

  uart_trig_eval #(.DEPTH(DEPTH)) u_trig (
    .cfg(cfg), .rx_level(rx_level), .tx_level(tx_level),
    .rx_trig(rx_trig), .tx_trig(tx_trig)
  );

  assign dma_mode = cfg.dma;

endmodule

// File: rtl/dual_fifo_trig_chk.sv
module dual_fifo_trig_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr,
  input logic [7:0]    ctl_data,
  input logic          fifo_en,
  input logic          tx_in_valid,
  input logic          tx_in_ready,
  input logic          tx_out_valid,
  input logic          tx_out_ready,
  input logic          rx_in_valid,
  input logic          rx_in_ready,
  input logic          rx_out_ready,
  input logic          rx_out_valid,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level,
  input logic          rx_trig,
  input logic          tx_trig,
  input logic          dma_mode,
  input logic          tx_err,
  input logic          rx_err
);

  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= CW'(DEPTH) && rx_level <= CW'(DEPTH)); // R2

  AST_HOLD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && tx_level != '0) |-> !tx_in_ready); // R3

  AST_TRIG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (!rx_trig && !tx_trig)); // R4

  AST_DMA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> dma_mode == $past(ctl_data[3])); // R7

  AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_data[2]) |=> tx_level == '0); // R8

  AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_data[1]) |=> rx_level == '0); // R9

  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_data[1] && rx_in_valid && rx_in_ready) |=> rx_level == '0); // R10

  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && !tx_in_ready) |=> tx_err); // R11

  AST_UDF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_ready && !rx_out_valid) |=> rx_err); // R11

  AST_OVF_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && !tx_in_ready && !(tx_out_valid && tx_out_ready) && !ctl_wr)
      |=> tx_level == $past(tx_level)); // R11

endmodule

bind dual_fifo_trig dual_fifo_trig_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
  .fifo_en(cfg.en), .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
  .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
  .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
  .rx_out_ready(rx_out_ready), .rx_out_valid(rx_out_valid),
  .tx_level(tx_level), .rx_level(rx_level), .rx_trig(rx_trig),
  .tx_trig(tx_trig), .dma_mode(dma_mode), .tx_err(tx_err), .rx_err(rx_err)
);

// File: tb/dual_fifo_trig_tb.sv
module dual_fifo_trig_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_data = '0;
  logic       enh_en = 1'b0;
  logic       tx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic       rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [7:0] tx_in_data = '0, rx_in_data = '0;
  logic       tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [7:0] tx_out_data, rx_out_data;
  logic [6:0] tx_level, rx_level;
  logic       rx_trig, tx_trig, dma_mode, tx_err, rx_err;

  int checks = 0;
  int errors = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  logic [7:0] seed = 8'h20;

  always #10 clk = ~clk;

  dual_fifo_trig u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data), .enh_en(enh_en),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .tx_level(tx_level), .rx_level(rx_level), .rx_trig(rx_trig), .tx_trig(tx_trig),
    .dma_mode(dma_mode), .tx_err(tx_err), .rx_err(rx_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic ctl_write(input logic [7:0] d, input logic enh);
    ctl_wr = 1'b1; ctl_data = d; enh_en = enh;
    tick();
    ctl_wr = 1'b0;
    if (d[2]) tx_q.delete();
    if (d[1]) rx_q.delete();
  endtask

  // driver: offers one character, records it as expected if accepted
  task automatic push(input bit is_rx);
    logic rdy;
    seed = seed + 8'd7;
    if (is_rx) begin rx_in_valid = 1'b1; rx_in_data = seed; end
    else       begin tx_in_valid = 1'b1; tx_in_data = seed; end
    #1;
    rdy = is_rx ? rx_in_ready : tx_in_ready;
    @(posedge clk);
    #2;
    rx_in_valid = 1'b0;
    tx_in_valid = 1'b0;
    if (rdy) begin
      if (is_rx) rx_q.push_back(seed);
      else       tx_q.push_back(seed);
    end
  endtask

  task automatic drain(input bit is_rx, input int n);
    if (is_rx) rx_out_ready = 1'b1; else tx_out_ready = 1'b1;
    repeat (n) @(posedge clk);
    #2;
    rx_out_ready = 1'b0;
    tx_out_ready = 1'b0;
  endtask

  // monitor: compares each handshake against the scoreboard (R2 ordering)
  always @(negedge clk) begin
    if (rst_n && tx_out_valid && tx_out_ready) begin
      if (tx_q.size() == 0) check("R2 tx unexpected pop", 1, 0);
      else check("R2 tx order", int'(tx_out_data), int'(tx_q.pop_front()));
    end
    if (rst_n && rx_out_valid && rx_out_ready) begin
      if (rx_q.size() == 0) check("R2 rx unexpected pop", 1, 0);
      else check("R2 rx order", int'(rx_out_data), int'(rx_q.pop_front()));
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 tx_level", int'(tx_level), 0);
    check("R1 rx_level", int'(rx_level), 0);
    check("R1 trig", int'({rx_trig, tx_trig}), 0);
    check("R1 dma_mode", int'(dma_mode), 0);
    check("R1 ready", int'({tx_in_ready, rx_in_ready}), 3);

    // R3 single-character holding while disabled
    push(0);
    check("R3 tx_level one", int'(tx_level), 1);
    check("R3 tx_in_ready low", int'(tx_in_ready), 0);
    push(0);
    check("R11 overflow err", int'(tx_err), 1);
    check("R11 overflow level", int'(tx_level), 1);
    tick();
    check("R11 err one cycle", int'(tx_err), 0);
    drain(0, 1);
    check("R3 tx drained", int'(tx_level), 0);
    drain(1, 1);
    check("R11 underflow err", int'(rx_err), 1);
    check("R11 underflow level", int'(rx_level), 0);

    // enable, receive thresholds (R4, R12)
    ctl_write(8'h01, 1'b0);
    check("R12 tx_trig after enable", int'(tx_trig), 1);
    for (int i = 0; i < 7; i++) push(1);
    check("R4 rx 7 below 8", int'(rx_trig), 0);
    push(1);
    check("R4 rx 8 at 8", int'(rx_trig), 1);
    ctl_write(8'h41, 1'b0);
    check("R4 rx 8 below 16", int'(rx_trig), 0);
    for (int i = 0; i < 8; i++) push(1);
    check("R4 rx 16 at 16", int'(rx_trig), 1);
    ctl_write(8'h81, 1'b0);
    for (int i = 0; i < 39; i++) push(1);
    check("R4 rx 55 below 56", int'(rx_trig), 0);
    push(1);
    check("R4 rx 56 at 56", int'(rx_trig), 1);
    ctl_write(8'hC1, 1'b0);
    for (int i = 0; i < 3; i++) push(1);
    check("R4 rx 59 below 60", int'(rx_trig), 0);
    push(1);
    check("R4 rx 60 at 60", int'(rx_trig), 1);
    for (int i = 0; i < 4; i++) push(1);
    check("R2 rx full level", int'(rx_level), 64);
    check("R2 rx ready low", int'(rx_in_ready), 0);
    push(1);
    check("R11 rx overflow err", int'(rx_err), 1);
    check("R11 rx overflow level", int'(rx_level), 64);
    drain(1, 61);
    check("R2 rx drained to 3", int'(rx_level), 3);

    // transmit thresholds, free = 24 (R5, R6)
    for (int i = 0; i < 40; i++) push(0);
    check("R5 free 24 vs 8", int'(tx_trig), 1);
    ctl_write(8'h21, 1'b0);
    check("R6 guarded write kept 8", int'(tx_trig), 1);
    ctl_write(8'h21, 1'b1);
    check("R5 free 24 vs 32", int'(tx_trig), 0);
    ctl_write(8'h11, 1'b1);
    check("R5 free 24 vs 16", int'(tx_trig), 1);
    ctl_write(8'h31, 1'b1);
    check("R5 free 24 vs 56", int'(tx_trig), 0);
    ctl_write(8'h01, 1'b0);
    check("R6 guarded write kept 56", int'(tx_trig), 0);

    // DMA mode (R7)
    ctl_write(8'h09, 1'b0);
    check("R7 dma mode 1", int'(dma_mode), 1);
    ctl_write(8'h01, 1'b0);
    check("R7 dma mode 0", int'(dma_mode), 0);

    // flushes (R8, R9, R12)
    ctl_write(8'h05, 1'b0);
    check("R8 tx flushed", int'(tx_level), 0);
    check("R8 rx untouched", int'(rx_level), 3);
    push(0);
    ctl_write(8'h01, 1'b0);
    check("R12 no sticky flush", int'(tx_level), 1);
    ctl_write(8'h03, 1'b0);
    check("R9 rx flushed", int'(rx_level), 0);
    check("R9 tx untouched", int'(tx_level), 1);

    // flush beats simultaneous push (R10)
    push(1);
    rx_in_valid = 1'b1; rx_in_data = 8'hA5;
    ctl_write(8'h03, 1'b0);
    rx_in_valid = 1'b0;
    check("R10 flush wins", int'(rx_level), 0);

    drain(0, 1);
    check("R2 tx queue consumed", int'(tx_level) + tx_q.size(), 0);
    tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule